// File: doc/BRIEF.md
# Serial Byte Buffering with Hardware Handshake

This block sits between a serial receiver/transmitter pair and the host-facing side of a bridge. Bytes arriving from the serial receiver are stored in a receive FIFO and handed to the host through a valid/ready read port. Bytes from the host are queued in a transmit FIFO and offered to the serial transmitter through a valid/ready handshake.

When hardware handshaking is switched on, the block steers the remote sender with an active-low request-to-send output. The output follows a fixed fill threshold that sits well below the receive FIFO's capacity. An active-low clear-to-send input is resynchronised and then gates the transmit handshake, so only a small, bounded number of bytes leave after the far end asks for a pause. A single-cycle flush empties both FIFOs. A write that finds the receive FIFO full is dropped and leaves a sticky flag.

Top module: `uart_flow_buffers`

## Requirements
- R1: The receive FIFO returns bytes on `rx_rd_data` in arrival order and holds up to RX_DEPTH (default 576) bytes. `rx_rd_valid` is high exactly when it is not empty, and a byte is removed on a cycle with `rx_rd_valid` and `rx_rd_ready` both high.
- R2: With `flow_en` high, `rts_n` is 0 while the receive FIFO holds fewer than RTS_MARK (default 383) bytes.
- R3: With `flow_en` high, `rts_n` is 1 from the cycle after the write that brings the level to RTS_MARK. It returns to 0 in the cycle after the level drops below RTS_MARK, with no hysteresis.
- R4: With `flow_en` low, `rts_n` stays 0 and `cts_n` has no effect on `tx_valid`.
- R5: `cts_n` passes through a two-flop synchronizer. With `flow_en` high and a ready transmitter, exactly two bytes are accepted after `cts_n` rises, and after that `tx_valid` stays 0 while `cts_n` remains 1.
- R6: A receive write while the FIFO holds RX_DEPTH bytes is dropped, and the stored bytes are kept. The drop sets `rx_overrun`, which stays 1 until a flush.
- R7: A one-cycle `flush` leaves both FIFOs empty and `rx_overrun` at 0 in the next cycle. A receive write in the same cycle as the flush is discarded.
- R8: The transmit FIFO holds up to TX_DEPTH (default 576) host bytes and sends them in order on `tx_data`. `tx_full` is 1 at TX_DEPTH, and a host write while full is ignored.
- R9: A receive write and a receive read in the same cycle leave the level unchanged, so `rts_n` holds its value at the threshold.
- R10: After reset both FIFOs are empty, `rts_n` is 0, `rx_overrun` is 0, `tx_full` is 0 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_en | input | 1 | Enables hardware handshaking |
| flush | input | 1 | Empties both FIFOs and clears the overrun flag |
| rx_wr_valid | input | 1 | Byte strobe from the serial receiver |
| rx_wr_data | input | 8 | Received byte |
| rx_rd_valid | output | 1 | Receive FIFO holds a byte |
| rx_rd_data | output | 8 | Oldest received byte |
| rx_rd_ready | input | 1 | Host takes the oldest received byte |
| host_tx_valid | input | 1 | Host writes a byte to transmit |
| host_tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO is full |
| tx_valid | output | 1 | A byte is offered to the serial transmitter |
| tx_data | output | 8 | Byte offered to the serial transmitter |
| tx_ready | input | 1 | Serial transmitter accepts the offered byte |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| rts_n | output | 1 | Active-low request-to-send to the far end |
| rx_overrun | output | 1 | Sticky flag for a dropped receive write |

## Verification
The receive FIFO can take a write and give up a read in the same cycle. At the threshold this decides whether `rts_n` flickers. The bench fills the FIFO to exactly RTS_MARK, raises write and read together for one cycle, and expects `rts_n` to stay high with the scoreboard order intact. A flush can also coincide with a receive write. That case is driven in one cycle, and the bench then requires an empty FIFO and a cleared flag.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
    localparam int BYTE_W       = 8;
    localparam int RX_DEPTH_DEF = 576;
    localparam int TX_DEPTH_DEF = 576;
    localparam int RTS_MARK_DEF = 383;
    localparam int SYNC_DEF     = 2;

    typedef struct packed {
        logic overrun;
    } flow_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 576,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } ptr_state_t;

    ptr_state_t    st_d, st_q;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push, do_pop;

    assign full  = (st_q.count == FULL_CNT);
    assign empty = (st_q.count == '0);
    assign count = st_q.count;

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push)
                st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + 1'b1;
            if (do_pop)
                st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= push_data;
    end

    assign pop_data = mem[st_q.rd_ptr];
endmodule

// File: rtl/sync_ff.sv
module sync_ff #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_flow_buffers.sv
module uart_flow_buffers
    import uart_flow_pkg::*;
#(
    parameter int RX_DEPTH = RX_DEPTH_DEF,
    parameter int TX_DEPTH = TX_DEPTH_DEF,
    parameter int RTS_MARK = RTS_MARK_DEF,
    parameter int SYNC_N   = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic              flush,
    input  logic              rx_wr_valid,
    input  logic [BYTE_W-1:0] rx_wr_data,
    output logic              rx_rd_valid,
    output logic [BYTE_W-1:0] rx_rd_data,
    input  logic              rx_rd_ready,
    input  logic              host_tx_valid,
    input  logic [BYTE_W-1:0] host_tx_data,
    output logic              tx_full,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              cts_n,
    output logic              rts_n,
    output logic              rx_overrun
);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam logic [RX_CW-1:0] MARK_CNT = RX_CW'(RTS_MARK);

    flow_state_t       state_d, state_q;
    logic [RX_CW-1:0]  rx_count;
    logic [TX_CW-1:0]  tx_count;
    logic              rx_full, rx_empty, tx_empty;
    logic              cts_n_sync;
    logic              tx_pop;

    byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) i_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (rx_wr_valid),
        .push_data(rx_wr_data),
        .pop      (rx_rd_ready),
        .pop_data (rx_rd_data),
        .count    (rx_count),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) i_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (host_tx_valid),
        .push_data(host_tx_data),
        .pop      (tx_pop),
        .pop_data (tx_data),
        .count    (tx_count),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    // Reset to 0 (clear) so a fresh start does not block transmission.
    sync_ff #(.STAGES(SYNC_N), .RESET_VAL(1'b0)) i_cts_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cts_n),
        .dout (cts_n_sync)
    );

    always_comb begin
        state_d = state_q;
        if (flush)
            state_d.overrun = 1'b0;
        else if (rx_wr_valid && rx_full)
            state_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rx_rd_valid = !rx_empty;
    assign tx_valid    = !tx_empty && !(flow_en && cts_n_sync);
    assign tx_pop      = tx_valid && tx_ready;
    assign rts_n       = flow_en && (rx_count >= MARK_CNT);
    assign rx_overrun  = state_q.overrun;
endmodule

// File: rtl/uart_flow_checker.sv
module uart_flow_checker #(
    parameter int RX_DEPTH = 576,
    parameter int RX_CW    = 10,
    parameter int TX_CW    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flow_en,
    input logic             flush,
    input logic             cts_n,
    input logic             rts_n,
    input logic             rx_wr_valid,
    input logic             rx_rd_valid,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_overrun,
    input logic [RX_CW-1:0] rx_count,
    input logic [TX_CW-1:0] tx_count
);
    logic [1:0] sent_after_stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sent_after_stop <= '0;
        else if (!flow_en || !cts_n)
            sent_after_stop <= '0;
        else if (tx_valid && tx_ready && sent_after_stop != 2'd3)
            sent_after_stop <= sent_after_stop + 2'd1;
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= RX_CW'(RX_DEPTH));

    assert_empty_view_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_rd_valid |-> rx_count == '0);

    assert_rts_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(flow_en)) |-> $past(rx_wr_valid));

    assert_rts_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> !rts_n);

    assert_cts_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sent_after_stop <= 2'd2);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !flush) |=> rx_overrun);

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_count == '0 && tx_count == '0 && !rx_overrun));
endmodule

bind uart_flow_buffers uart_flow_checker #(
    .RX_DEPTH(RX_DEPTH),
    .RX_CW   (RX_CW),
    .TX_CW   (TX_CW)
) i_uart_flow_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_en    (flow_en),
    .flush      (flush),
    .cts_n      (cts_n),
    .rts_n      (rts_n),
    .rx_wr_valid(rx_wr_valid),
    .rx_rd_valid(rx_rd_valid),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_overrun (rx_overrun),
    .rx_count   (rx_count),
    .tx_count   (tx_count)
);

// File: tb/test_uart_flow_buffers.sv
module test_uart_flow_buffers;
    localparam int RXD  = 576;
    localparam int TXD  = 576;
    localparam int MARK = 383;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flow_en = 1'b0, flush = 1'b0;
    logic       rx_wr_valid = 1'b0, rx_rd_ready = 1'b0;
    logic [7:0] rx_wr_data = '0, host_tx_data = '0;
    logic       host_tx_valid = 1'b0, tx_ready = 1'b0, cts_n = 1'b0;
    logic       rx_rd_valid, tx_full, tx_valid, rts_n, rx_overrun;
    logic [7:0] rx_rd_data, tx_data;

    int total = 0, fails = 0, tx_acc = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    always #10 clk = ~clk;

    uart_flow_buffers i_uart_flow_buffers (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .flush(flush),
        .rx_wr_valid(rx_wr_valid), .rx_wr_data(rx_wr_data),
        .rx_rd_valid(rx_rd_valid), .rx_rd_data(rx_rd_data), .rx_rd_ready(rx_rd_ready),
        .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data), .tx_full(tx_full),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .cts_n(cts_n), .rts_n(rts_n), .rx_overrun(rx_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: handshakes seen at the falling edge complete at the next rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_rd_valid && rx_rd_ready) begin
                if (rxq.size() == 0) chk(1'b0, "R1", int'(rx_rd_data), -1);
                else begin
                    automatic logic [7:0] e = rxq.pop_front();
                    chk(rx_rd_data == e, "R1", int'(rx_rd_data), int'(e));
                end
            end
            if (tx_valid && tx_ready) begin
                tx_acc++;
                if (txq.size() == 0) chk(1'b0, "R8", int'(tx_data), -1);
                else begin
                    automatic logic [7:0] e = txq.pop_front();
                    chk(tx_data == e, "R8", int'(tx_data), int'(e));
                end
            end
        end
    end

    task automatic rx_write(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rx_wr_valid = 1'b1;
            rx_wr_data  = 8'(base + i);
            if (rxq.size() < RXD) rxq.push_back(8'(base + i));
        end
        @(posedge clk); #2;
        rx_wr_valid = 1'b0;
    endtask

    task automatic rx_read(input int n);
        @(posedge clk); #2;
        rx_rd_ready = 1'b1;
        repeat (n) @(posedge clk);
        #2;
        rx_rd_ready = 1'b0;
    endtask

    task automatic host_write(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            host_tx_valid = 1'b1;
            host_tx_data  = 8'(base + i);
            if (txq.size() < TXD) txq.push_back(8'(base + i));
        end
        @(posedge clk); #2;
        host_tx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int a0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(rts_n == 1'b0,      "R10", rts_n, 0);
        chk(rx_rd_valid == 1'b0, "R10", rx_rd_valid, 0);
        chk(tx_valid == 1'b0,   "R10", tx_valid, 0);
        chk(rx_overrun == 1'b0, "R10", rx_overrun, 0);
        chk(tx_full == 1'b0,    "R10", tx_full, 0);

        @(posedge clk); #2 flow_en = 1'b1;
        rx_write(MARK - 1, 0);
        @(negedge clk) chk(rts_n == 1'b0, "R2", rts_n, 0);
        rx_write(1, 7);
        @(negedge clk) chk(rts_n == 1'b1, "R3", rts_n, 1);
        // R9: simultaneous write and read at the threshold
        @(posedge clk); #2;
        rx_wr_valid = 1'b1; rx_wr_data = 8'hA5; rx_rd_ready = 1'b1;
        rxq.push_back(8'hA5);
        @(posedge clk); #2;
        rx_wr_valid = 1'b0; rx_rd_ready = 1'b0;
        @(negedge clk) chk(rts_n == 1'b1, "R9", rts_n, 1);
        rx_read(1);
        @(negedge clk) chk(rts_n == 1'b0, "R3", rts_n, 0);

        rx_write(RXD - MARK + 1, 50);
        @(negedge clk) chk(rx_overrun == 1'b0, "R6", rx_overrun, 0);
        rx_write(3, 200);
        @(negedge clk) chk(rx_overrun == 1'b1, "R6", rx_overrun, 1);
        @(posedge clk); #2 flow_en = 1'b0;
        @(negedge clk) chk(rts_n == 1'b0, "R4", rts_n, 0);
        @(posedge clk); #2 flow_en = 1'b1;
        rx_read(RXD + 2);
        @(negedge clk);
        chk(rx_rd_valid == 1'b0, "R1", rx_rd_valid, 0);
        chk(rxq.size() == 0,     "R6", rxq.size(), 0);
        chk(rx_overrun == 1'b1,  "R6", rx_overrun, 1);

        // R7: flush with a concurrent receive write
        rx_write(5, 90);
        host_write(4, 30);
        @(negedge clk) chk(tx_valid == 1'b1, "R8", tx_valid, 1);
        @(posedge clk); #2;
        flush = 1'b1; rx_wr_valid = 1'b1; rx_wr_data = 8'h3C;
        @(posedge clk); #2;
        flush = 1'b0; rx_wr_valid = 1'b0;
        rxq.delete(); txq.delete();
        @(negedge clk);
        chk(rx_rd_valid == 1'b0, "R7", rx_rd_valid, 0);
        chk(tx_valid == 1'b0,    "R7", tx_valid, 0);
        chk(rx_overrun == 1'b0,  "R7", rx_overrun, 0);

        host_write(TXD, 0);
        @(negedge clk) chk(tx_full == 1'b1, "R8", tx_full, 1);
        host_write(2, 77);

        // R5: two more bytes after clear-to-send goes inactive
        a0 = tx_acc;
        @(posedge clk); #2 tx_ready = 1'b1;
        repeat (10) @(posedge clk);
        #2 cts_n = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(tx_acc - a0 == 12,  "R5", tx_acc - a0, 12);
        chk(tx_valid == 1'b0,   "R5", tx_valid, 0);
        @(posedge clk); #2 flow_en = 1'b0;
        @(negedge clk) chk(tx_valid == 1'b1, "R4", tx_valid, 1);
        repeat (TXD) @(posedge clk);
        @(negedge clk);
        chk(txq.size() == 0,  "R8", txq.size(), 0);
        chk(tx_valid == 1'b0, "R8", tx_valid, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule